// File: doc/BRIEF.md
# Manchester Line Receiver with Digital Clock Recovery

This block recovers data from a single wire that carries a Manchester-coded bit stream with no separate clock. Each bit cell holds exactly one guaranteed transition at its midpoint. An upward midpoint transition encodes a one and a downward one encodes a zero. An extra transition at the cell edge appears only between two equal bits. The wire is asynchronous to the receiver. The block samples it at a fixed multiple of the nominal bit rate and keeps a local bit-phase counter aligned to the midpoint transitions. This alignment uses a small bang-bang tracking loop.

The stream has no start bits, no stop bits and no word length, so the block does no framing. Each accepted midpoint transition gives a one-cycle strobe with the decoded bit, and the bits form a continuous sequence. A lock flag tells the consumer when the loop has settled on the stream and when it has lost it. Grouping bits into words is left to the logic that follows.

Top module: `manch_rx`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `bit_valid` and `locked` are 0.
- R2: An upward transition accepted as a midpoint gives a one-cycle `bit_valid` pulse with `bit_data` = 1, and a downward one gives `bit_data` = 0. The pulse is visible after the third rising clock edge counted from the edge that first samples the new line level. This holds whether or not the block is locked.
- R3: The bit-phase counter runs from 0 to OVS-1 and the expected midpoint is at count OVS/2. A transition is accepted as a midpoint only when the counter is within ±WIN of OVS/2 (counts 5 to 11 with defaults).
- R4: While locked, a transition outside the window produces no pulse and leaves the counter and the lock state unchanged. This is how optional cell-edge transitions between equal bits are discarded.
- R5: `locked` rises with the pulse of the LOCK_HITS-th consecutive accepted midpoint (8 by default). A transition outside the window while unlocked restarts that count.
- R6: `locked` falls once LOSS_BITS·OVS clock cycles (32 by default) pass with no accepted midpoint.
- R7: An accepted midpoint seen before OVS/2 advances the counter by 2 instead of 1, and one seen after OVS/2 holds it for one cycle. With this, streams whose bit cell is 15 or 17 samples long decode without errors.
- R8: While unlocked, a transition outside the window emits no pulse and loads the counter so that the transition counts as a midpoint: it holds OVS/2+1 on the next cycle. Lock can therefore be acquired from any starting phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock, OVS times the nominal bit rate |
| rst_n | input | 1 | Synchronous reset, active low |
| line_in | input | 1 | Asynchronous Manchester-coded line |
| bit_valid | output | 1 | One-cycle strobe for each decoded bit |
| bit_data | output | 1 | Decoded bit, meaningful while `bit_valid` is 1 |
| locked | output | 1 | Loop is aligned to the incoming midpoints |

## Verification
An alternating preamble has no cell-edge transitions, so it shows clean acquisition from an arbitrary phase. Long runs of equal bits put a transition at every cell edge, and they show whether those decoy edges are rejected. Pseudo-random data mixes both cases. Single cells with their midpoint moved by three or four samples find the exact window edge. Streams with 15- and 17-sample cells show whether the phase nudge keeps up with a rate offset. An idle line followed by a preamble that starts on a decoy edge covers loss of lock and re-acquisition through the realign path.

// File: rtl/mrx_pkg.sv
// Package: shared types for the Manchester receiver.
// Assumes nothing beyond the standard; holds the edge descriptor only.
package mrx_pkg;

    // Direction of a transition seen on the synchronized line.
    typedef struct packed {
        logic rise;
        logic fall;
    } mrx_edge_t;

endpackage

// File: rtl/mrx_edge_sync.sv
// mrx_edge_sync: brings the asynchronous line into the clock domain
// through SYNC_STAGES flops and flags rising and falling transitions.
// Assumes the line stays at each level for more than one clock period.
module mrx_edge_sync
    import mrx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      line_in,
    output logic      lvl,
    output mrx_edge_t edg
);

    logic [SYNC_STAGES:0] chain;

    // Shift the raw line through the synchronizer plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[SYNC_STAGES-1:0], line_in};
        end
    end

    // Compare the synchronized level with its previous value.
    always_comb begin
        lvl      = chain[SYNC_STAGES-1];
        edg.rise = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
        edg.fall = ~chain[SYNC_STAGES-1] & chain[SYNC_STAGES];
    end

endmodule

// File: rtl/mrx_phase_track.sv
// mrx_phase_track: bit-phase counter with a midpoint window. It makes
// the bit decision and nudges the phase by one sample toward each
// accepted edge. Unlocked, a stray edge realigns the counter.
// Assumes OVS >= 4 and WIN < OVS/2.
module mrx_phase_track
    import mrx_pkg::*;
#(
    parameter int OVS = 16,
    parameter int WIN = 3,
    localparam int PH_W = $clog2(OVS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  mrx_edge_t       edg,
    input  logic            locked,
    output logic            centre_hit,
    output logic            stray_edge,
    output logic [PH_W-1:0] phase,
    output logic            bit_valid,
    output logic            bit_data
);

    localparam int CTR = OVS / 2;
    localparam logic [PH_W-1:0] CTR_P  = PH_W'(CTR);
    localparam logic [PH_W-1:0] CTR_P1 = PH_W'(CTR + 1);
    localparam logic [PH_W-1:0] WIN_LO = PH_W'(CTR - WIN);
    localparam logic [PH_W-1:0] WIN_HI = PH_W'(CTR + WIN);
    localparam logic [PH_W:0]   OVS_W  = (PH_W+1)'(OVS);

    logic            any_edge;
    logic            in_win;
    logic [1:0]      step;
    logic [PH_W:0]   sum;
    logic [PH_W:0]   wrapped;

    // Classify the current edge against the midpoint window.
    always_comb begin
        any_edge   = edg.rise | edg.fall;
        in_win     = (phase >= WIN_LO) && (phase <= WIN_HI);
        centre_hit = any_edge & in_win;
        stray_edge = any_edge & ~in_win;
    end

    // Pick the counter step: +2 for an early midpoint, 0 for a late one.
    always_comb begin
        if (centre_hit && (phase < CTR_P)) begin
            step = 2'd2;
        end else if (centre_hit && (phase > CTR_P)) begin
            step = 2'd0;
        end else begin
            step = 2'd1;
        end
        sum     = {1'b0, phase} + (PH_W+1)'(step);
        wrapped = (sum >= OVS_W) ? (sum - OVS_W) : sum;
    end

    // Advance the counter, or realign it on a stray edge while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (stray_edge && !locked) begin
            phase <= CTR_P1;
        end else begin
            phase <= wrapped[PH_W-1:0];
        end
    end

    // Register the bit decision at the midpoint edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_valid <= 1'b0;
            bit_data  <= 1'b0;
        end else begin
            bit_valid <= centre_hit;
            bit_data  <= edg.rise;
        end
    end

endmodule

// File: rtl/mrx_lock_mon.sv
// mrx_lock_mon: declares lock after LOCK_HITS consecutive midpoints and
// drops it after LOSS_BITS bit periods with no midpoint.
// Assumes hit and stray are never both high.
module mrx_lock_mon #(
    parameter int OVS       = 16,
    parameter int LOCK_HITS = 8,
    parameter int LOSS_BITS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic stray,
    output logic locked
);

    localparam int LOSS = LOSS_BITS * OVS;
    localparam int GW   = $clog2(LOCK_HITS + 1);
    localparam int IW   = $clog2(LOSS + 1);
    localparam logic [GW-1:0] GOOD_LAST = GW'(LOCK_HITS - 1);
    localparam logic [IW-1:0] IDLE_LAST = IW'(LOSS - 1);

    logic [GW-1:0] good_cnt;
    logic [IW-1:0] idle_cnt;

    // Count consecutive hits while unlocked, quiet cycles while locked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked   <= 1'b0;
            good_cnt <= '0;
            idle_cnt <= '0;
        end else if (!locked) begin
            if (hit) begin
                if (good_cnt == GOOD_LAST) begin
                    locked   <= 1'b1;
                    good_cnt <= '0;
                    idle_cnt <= '0;
                end else begin
                    good_cnt <= good_cnt + 1'b1;
                end
            end else if (stray) begin
                good_cnt <= '0;
            end
        end else begin
            if (hit) begin
                idle_cnt <= '0;
            end else if (idle_cnt == IDLE_LAST) begin
                locked   <= 1'b0;
                idle_cnt <= '0;
            end else begin
                idle_cnt <= idle_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/manch_rx.sv
// manch_rx: Manchester receiver top. It joins the synchronizer, the
// phase tracker and the lock monitor. It assumes clk runs at OVS times
// the nominal bit rate and that line_in is asynchronous to it.
module manch_rx
    import mrx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int WIN         = 3,
    parameter int LOCK_HITS   = 8,
    parameter int LOSS_BITS   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic bit_valid,
    output logic bit_data,
    output logic locked
);

    localparam int PH_W = $clog2(OVS);

    mrx_edge_t       edge_s;
    logic            lvl_sync;
    logic            centre_hit;
    logic            stray_edge;
    logic [PH_W-1:0] phase;

    mrx_edge_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_in(line_in),
        .lvl    (lvl_sync),
        .edg    (edge_s)
    );

    mrx_phase_track #(
        .OVS(OVS),
        .WIN(WIN)
    ) track_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .edg       (edge_s),
        .locked    (locked),
        .centre_hit(centre_hit),
        .stray_edge(stray_edge),
        .phase     (phase),
        .bit_valid (bit_valid),
        .bit_data  (bit_data)
    );

    mrx_lock_mon #(
        .OVS      (OVS),
        .LOCK_HITS(LOCK_HITS),
        .LOSS_BITS(LOSS_BITS)
    ) lock_i (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (centre_hit),
        .stray (stray_edge),
        .locked(locked)
    );

endmodule

// File: rtl/mrx_checker.sv
// mrx_checker: temporal properties of manch_rx, attached by bind.
// Assumes the default window placement WIN < OVS/2.
module mrx_checker #(
    parameter int OVS = 16,
    parameter int WIN = 3,
    localparam int PH_W = $clog2(OVS)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bit_valid,
    input logic            bit_data,
    input logic            locked,
    input logic            lvl,
    input logic            rise,
    input logic            fall,
    input logic [PH_W-1:0] phase
);

    localparam logic [PH_W-1:0] C_P  = PH_W'(OVS / 2);
    localparam logic [PH_W-1:0] C_P1 = PH_W'(OVS / 2 + 1);
    localparam logic [PH_W-1:0] LO   = PH_W'(OVS / 2 - WIN);
    localparam logic [PH_W-1:0] HI   = PH_W'(OVS / 2 + WIN);

    logic out_win;
    assign out_win = (phase < LO) || (phase > HI);

    AST_VALID_FOLLOWS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> $past(rise || fall)); // R2
    AST_DATA_MATCHES_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> (bit_data == $past(lvl))); // R2
    AST_STRAY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && (rise || fall) && out_win) |=> !bit_valid); // R4
    AST_LOCK_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> bit_valid); // R5
    AST_UNLOCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> !bit_valid); // R6
    AST_EARLY_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise || fall) && (phase >= LO) && (phase < C_P)) |=> (phase == $past(phase) + PH_W'(2))); // R7
    AST_LATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise || fall) && (phase > C_P) && (phase <= HI)) |=> $stable(phase)); // R7
    AST_UNLOCKED_REALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && (rise || fall) && out_win) |=> (phase == C_P1)); // R8

endmodule

bind manch_rx mrx_checker #(
    .OVS(OVS),
    .WIN(WIN)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_valid(bit_valid),
    .bit_data (bit_data),
    .locked   (locked),
    .lvl      (lvl_sync),
    .rise     (edge_s.rise),
    .fall     (edge_s.fall),
    .phase    (phase)
);

// File: tb/manch_rx_tb_top.sv
`timescale 1ns/1ps
// manch_rx_tb_top: drives Manchester cells, runs a behavioural model on
// every clock and compares it with the design; adds targeted checks.
module manch_rx_tb_top;

    localparam int OVS  = 16;
    localparam int WIN  = 3;
    localparam int HITS = 8;
    localparam int LOSS = 2 * OVS;
    localparam int C    = OVS / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_in = 1'b0;
    logic bit_valid, bit_data, locked;

    int vectors = 0;
    int miscompares = 0;
    int pulses = 0;
    bit got[$];
    bit sent[$];
    bit last_bit = 1'b0;
    int lfsr = 16'hACE1;

    // Reference model state.
    int  a1, a2, a3, mph, mgood, midle;
    bit  mlock, mval, mdat;

    manch_rx dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_in  (line_in),
        .bit_valid(bit_valid),
        .bit_data (bit_data),
        .locked   (locked)
    );

    always #2 clk = ~clk;

    // Behavioural model of the receiver, stepped on each rising edge.
    always @(posedge clk) begin
        bit r, f, e, w;
        int nph;
        if (!rst_n) begin
            a1 = 0; a2 = 0; a3 = 0; mph = 0; mgood = 0; midle = 0;
            mlock = 0; mval = 0; mdat = 0;
        end else begin
            r = (a2 == 1) && (a3 == 0);
            f = (a2 == 0) && (a3 == 1);
            e = r || f;
            w = e && (mph >= C - WIN) && (mph <= C + WIN);
            if (w) nph = (mph < C) ? mph + 2 : (mph > C) ? mph : mph + 1;
            else if (e && !mlock) nph = C + 1;
            else nph = mph + 1;
            nph = nph % OVS;
            mval = w;
            mdat = r;
            if (!mlock) begin
                if (w) begin
                    if (mgood == HITS - 1) begin mlock = 1; mgood = 0; midle = 0; end
                    else mgood++;
                end else if (e) mgood = 0;
            end else begin
                if (w) midle = 0;
                else if (midle == LOSS - 1) begin mlock = 0; midle = 0; end
                else midle++;
            end
            a3 = a2; a2 = a1; a1 = int'(line_in);
            mph = nph;
        end
    end

    // Compare design and model away from the active edge; log bits.
    always @(negedge clk) begin
        if (rst_n) begin
            vectors++;
            if (bit_valid !== mval) begin
                miscompares++;
                $display("FAIL R2 bit_valid actual=%0b expected=%0b t=%0t", bit_valid, mval, $time);
            end
            if (bit_valid && mval && (bit_data !== mdat)) begin
                miscompares++;
                $display("FAIL R2 bit_data actual=%0b expected=%0b t=%0t", bit_data, mdat, $time);
            end
            if (locked !== mlock) begin
                miscompares++;
                $display("FAIL R5 locked actual=%0b expected=%0b t=%0t", locked, mlock, $time);
            end
            if (bit_valid) begin
                pulses++;
                got.push_back(bit_data);
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic hold(input bit lv, input int n);
        line_in = lv;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input bit b, input int h1, input int h2);
        hold(!b, h1);
        hold(b, h2);
        sent.push_back(b);
        last_bit = b;
    endtask

    task automatic send_rand(input int n, input int h1, input int h2);
        for (int i = 0; i < n; i++) begin
            lfsr = ((lfsr >> 1) ^ ((lfsr & 1) ? 16'hB400 : 0)) & 16'hFFFF;
            send_bit(lfsr[0], h1, h2);
        end
    endtask

    task automatic cmp_tail(input int k, input string req);
        check(got.size() >= k, req, "decoded bit count", got.size(), k);
        if (got.size() >= k) begin
            for (int i = 0; i < k; i++) begin
                check(got[got.size()-1-i] == sent[sent.size()-1-i], req, "decoded bit",
                      got[got.size()-1-i], sent[sent.size()-1-i]);
            end
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        int p0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet outputs after reset.
        check(bit_valid == 0, "R1", "bit_valid after reset", bit_valid, 0);
        check(locked == 0, "R1", "locked after reset", locked, 0);
        hold(1'b0, 3);

        // R5: alternating preamble acquires lock.
        for (int i = 0; i < 12; i++) send_bit(i % 2 == 0, 8, 8);
        check(locked == 1, "R5", "locked after preamble", locked, 1);

        // R3: midpoint 3 samples late still accepted.
        send_bit(!last_bit, 8, 8);
        p0 = pulses;
        send_bit(!last_bit, 11, 5);
        send_bit(!last_bit, 8, 8);
        check(pulses - p0 == 2, "R3", "pulses with edge at window edge", pulses - p0, 2);
        // R3, R4: midpoint 4 samples late falls outside and is dropped.
        send_bit(!last_bit, 8, 8);
        p0 = pulses;
        send_bit(!last_bit, 12, 4);
        send_bit(!last_bit, 8, 8);
        check(pulses - p0 == 1, "R4", "pulses with edge outside window", pulses - p0, 1);
        check(locked == 1, "R4", "lock kept after stray edge", locked, 1);

        // R2: pseudo-random data at nominal rate.
        send_rand(40, 8, 8);
        cmp_tail(32, "R2");

        // R4: equal-bit runs put decoy edges at every cell boundary.
        p0 = pulses;
        for (int i = 0; i < 16; i++) send_bit(1'b0, 8, 8);
        check(pulses - p0 == 16, "R4", "pulses over zero run", pulses - p0, 16);
        cmp_tail(16, "R4");
        p0 = pulses;
        for (int i = 0; i < 16; i++) send_bit(1'b1, 8, 8);
        check(pulses - p0 == 16, "R4", "pulses over one run", pulses - p0, 16);
        cmp_tail(16, "R4");

        // R7: slow and fast cells are tracked.
        send_rand(40, 8, 9);
        cmp_tail(32, "R7");
        check(locked == 1, "R7", "locked with 17-sample cells", locked, 1);
        send_rand(40, 7, 8);
        cmp_tail(32, "R7");
        check(locked == 1, "R7", "locked with 15-sample cells", locked, 1);

        // R6: idle line drops lock after two bit periods without midpoints.
        hold(last_bit, 16);
        check(locked == 1, "R6", "locked early in idle", locked, 1);
        hold(last_bit, 32);
        check(locked == 0, "R6", "locked after idle", locked, 0);

        // R8: re-acquire from an odd phase, starting on a decoy edge.
        hold(last_bit, 5);
        begin
            bit b0;
            b0 = last_bit;
            for (int i = 0; i < 12; i++) send_bit((i % 2 == 0) ? b0 : !b0, 8, 8);
        end
        check(locked == 1, "R8", "locked after re-acquisition", locked, 1);
        send_rand(24, 8, 8);
        cmp_tail(20, "R8");

        hold(last_bit, 4);
        summary();
        $finish;
    end

endmodule